// File: doc/BRIEF.md
# Prefetch Usefulness Monitor

This block sits next to a set-associative data cache bank and measures how much software prefetching helps. It does not hold data or tags. It only observes the bank's event strobes: requests firing from the core, misses pushed toward memory, line fills, hits, evictions, and the result of matching a new request against misses that are still in flight. For every cache line it keeps two flags. One records that the line arrived because of a prefetch. The other records that a demand access has touched it since then.

From these events the monitor keeps three saturating event counts:
- prefetch misses that actually went out to memory;
- prefetched lines that were evicted without ever being used;
- prefetches that arrived too late because a demand miss to the same address was already outstanding.

Software reads the counts through a simple registered read port. Each count is split into a low 32-bit word and a high 32-bit word at fixed addresses.

Top module: `pfm_monitor`

## Requirements
- R1: The prefetch flag of a request is bit 0 of its tag (1 = prefetch, 0 = demand). The unique count rises by one in every cycle where `mreqPush` is high and `mreqTag[0]` is 1. A push with `mreqTag[0]` = 0 leaves it unchanged.
- R2: The late count rises by one in every cycle where `reqFire` is high, `reqTag[0]` is 1, `mshrMatch` is 1 and `mshrMatchPf` is 0. With no match, or when the matching miss is itself a prefetch, the count does not change.
- R3: A fill (`fillValid`) on line (`fillSet`, `fillWay`) copies `fillIsPf` into the line's prefetched flag and clears its used flag.
- R4: A demand hit (`reqFire`, `reqHit`, `reqTag[0]` = 0) sets the used flag of line (`reqSet`, `reqWay`). A prefetch hit leaves the used flag unchanged.
- R5: An eviction (`evictValid`) of a line whose prefetched flag is 1 and whose used flag is 0 raises the unused count by one. The eviction then clears both flags, unless a fill targets the same line in that cycle.
- R6: When an eviction and a fill name the same line in one cycle, the eviction is judged on the flags as they stood before the edge, and the line ends with the flags set by the fill.
- R7: Each count saturates at 2^CNT_W - 1 and holds there instead of wrapping.
- R8: A synchronous reset (`rst` high) clears all three counts, all line flags and the read data.
- R9: Read addresses 0xB20, 0xB21 and 0xB22 return bits 31:0 of the unique, unused and late counts. Addresses 0xBA0, 0xBA1 and 0xBA2 return bits 63:32 of the same counts, in the same order (counts narrower than 64 bits are zero-extended). The data appears on `csrRdData` one clock after the address is presented.
- R10: Any other read address returns zero one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqFire | input | 1 | A core request is accepted this cycle |
| reqTag | input | TAG_W | Tag of that request; bit 0 is the prefetch flag |
| reqHit | input | 1 | The accepted request hit in the cache |
| reqSet | input | SET_W | Set index of the hit line |
| reqWay | input | WAY_W | Way of the hit line |
| mshrMatch | input | 1 | The request address matches an outstanding miss |
| mshrMatchPf | input | 1 | The matched outstanding miss was a prefetch |
| mreqPush | input | 1 | A miss request is pushed toward memory |
| mreqTag | input | TAG_W | Tag of the request behind that miss; bit 0 is the prefetch flag |
| fillValid | input | 1 | A line is being filled |
| fillIsPf | input | 1 | The fill answers a prefetch miss |
| fillSet | input | SET_W | Set of the filled line |
| fillWay | input | WAY_W | Way of the filled line |
| evictValid | input | 1 | A line is being evicted |
| evictSet | input | SET_W | Set of the evicted line |
| evictWay | input | WAY_W | Way of the evicted line |
| csrAddr | input | 12 | Read address |
| csrRdData | output | 32 | Read data, one cycle after the address |

## Verification
The bench targets the following cases and the failure each would expose:
- A prefetch that merely hits must not count as use. A design that marks it used would hide an unused prefetched line at eviction.
- An eviction and a fill on the same line in the same cycle must be judged on the old flags. A design that reads the new flags would count a brand-new prefetched line as wasted.
- A second eviction of a line already evicted must not count again. A design that fails to clear the flags at eviction would double count.
- A late prefetch must only be counted against a demand miss. A design that ignores `mshrMatchPf`, or counts demand requests, would inflate the late count.
- A narrow-counter instance is pushed past its ceiling. A wrapping counter would return to small values.
- Reads of the high words, and of addresses outside the map, must return zero.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  localparam logic [11:0] CSR_LO_BASE = 12'hB20;
  localparam logic [11:0] CSR_HI_BASE = 12'hBA0;
  localparam int          NUM_COUNTS  = 3;

  localparam int IDX_UNIQUE = 0;
  localparam int IDX_UNUSED = 1;
  localparam int IDX_LATE   = 2;

  typedef struct packed {
    logic incUnique;
    logic incLate;
    logic evictChk;
    logic fillWr;
    logic fillPf;
    logic useMark;
  } pfm_strobe_t;

endpackage

// File: rtl/pfm_sat_counter.sv
module pfm_sat_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (inc && (value != MAX_VAL)) begin
      value <= value + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pfm_ctrl.sv
module pfm_ctrl #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int LINES   = NUM_SETS * NUM_WAYS,
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic                 reqFire,
  input  logic [TAG_W-1:0]     reqTag,
  input  logic                 reqHit,
  input  logic [SET_W-1:0]     reqSet,
  input  logic [WAY_W-1:0]     reqWay,
  input  logic                 mshrMatch,
  input  logic                 mshrMatchPf,
  input  logic                 mreqPush,
  input  logic [TAG_W-1:0]     mreqTag,
  input  logic                 fillValid,
  input  logic                 fillIsPf,
  input  logic [SET_W-1:0]     fillSet,
  input  logic [WAY_W-1:0]     fillWay,
  input  logic                 evictValid,
  input  logic [SET_W-1:0]     evictSet,
  input  logic [WAY_W-1:0]     evictWay,
  output pfm_pkg::pfm_strobe_t strobe,
  output logic [LINE_W-1:0]    useIdx,
  output logic [LINE_W-1:0]    fillIdx,
  output logic [LINE_W-1:0]    evictIdx
);

  logic reqIsPf;
  logic missIsPf;

  // Prefetch flag rides in the lowest tag bit.
  assign reqIsPf  = reqTag[0];
  assign missIsPf = mreqTag[0];

  function automatic logic [LINE_W-1:0] lineOf(input logic [SET_W-1:0] s,
                                               input logic [WAY_W-1:0] w);
    return LINE_W'(s) * LINE_W'(NUM_WAYS) + LINE_W'(w);
  endfunction

  always_comb begin
    strobe.incUnique = mreqPush & missIsPf;
    strobe.incLate   = reqFire & reqIsPf & mshrMatch & ~mshrMatchPf;
    strobe.evictChk  = evictValid;
    strobe.fillWr    = fillValid;
    strobe.fillPf    = fillIsPf;
    strobe.useMark   = reqFire & reqHit & ~reqIsPf;
  end

  assign useIdx   = lineOf(reqSet, reqWay);
  assign fillIdx  = lineOf(fillSet, fillWay);
  assign evictIdx = lineOf(evictSet, evictWay);

endmodule

// File: rtl/pfm_datapath.sv
module pfm_datapath #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 64,
  localparam int LINES   = NUM_SETS * NUM_WAYS,
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  pfm_pkg::pfm_strobe_t                     strobe,
  input  logic [LINE_W-1:0]                        useIdx,
  input  logic [LINE_W-1:0]                        fillIdx,
  input  logic [LINE_W-1:0]                        evictIdx,
  output logic [pfm_pkg::NUM_COUNTS-1:0][CNT_W-1:0] countVal
);

  import pfm_pkg::*;

  logic [LINES-1:0]      pfBits;
  logic [LINES-1:0]      usedBits;
  logic                  incUnused;
  logic [NUM_COUNTS-1:0] incVec;

  // Judged on the flags held before this edge, so a same-cycle fill cannot mask it.
  assign incUnused = strobe.evictChk & pfBits[evictIdx] & ~usedBits[evictIdx];

  genvar li;
  generate
    for (li = 0; li < LINES; li++) begin : g_line
      logic fillHere;
      logic evictHere;
      logic useHere;

      assign fillHere  = strobe.fillWr   && (fillIdx  == LINE_W'(li));
      assign evictHere = strobe.evictChk && (evictIdx == LINE_W'(li));
      assign useHere   = strobe.useMark  && (useIdx   == LINE_W'(li));

      always_ff @(posedge clk) begin
        if (rst) begin
          pfBits[li]   <= 1'b0;
          usedBits[li] <= 1'b0;
        end else if (fillHere) begin
          pfBits[li]   <= strobe.fillPf;
          usedBits[li] <= 1'b0;
        end else if (evictHere) begin
          pfBits[li]   <= 1'b0;
          usedBits[li] <= 1'b0;
        end else if (useHere) begin
          usedBits[li] <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    incVec             = '0;
    incVec[IDX_UNIQUE] = strobe.incUnique;
    incVec[IDX_UNUSED] = incUnused;
    incVec[IDX_LATE]   = strobe.incLate;
  end

  genvar ci;
  generate
    for (ci = 0; ci < NUM_COUNTS; ci++) begin : g_cnt
      pfm_sat_counter #(.CNT_W(CNT_W)) uCnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (incVec[ci]),
        .value (countVal[ci])
      );
    end
  endgenerate

endmodule

// File: rtl/pfm_csr_read.sv
module pfm_csr_read #(
  parameter int CNT_W = 64
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [11:0]                              csrAddr,
  input  logic [pfm_pkg::NUM_COUNTS-1:0][CNT_W-1:0] countVal,
  output logic [31:0]                              csrRdData
);

  import pfm_pkg::*;

  logic [NUM_COUNTS-1:0][63:0] wideVal;
  logic [31:0]                 rdNext;

  genvar wi;
  generate
    for (wi = 0; wi < NUM_COUNTS; wi++) begin : g_wide
      assign wideVal[wi] = 64'(countVal[wi]);
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_COUNTS; i++) begin
      if (csrAddr == CSR_LO_BASE + 12'(i)) rdNext = wideVal[i][31:0];
      if (csrAddr == CSR_HI_BASE + 12'(i)) rdNext = wideVal[i][63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) csrRdData <= '0;
    else     csrRdData <= rdNext;
  end

endmodule

// File: rtl/pfm_monitor.sv
module pfm_monitor #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 64,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int LINE_W  = $clog2(NUM_SETS * NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqFire,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             reqHit,
  input  logic [SET_W-1:0] reqSet,
  input  logic [WAY_W-1:0] reqWay,
  input  logic             mshrMatch,
  input  logic             mshrMatchPf,
  input  logic             mreqPush,
  input  logic [TAG_W-1:0] mreqTag,
  input  logic             fillValid,
  input  logic             fillIsPf,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             evictValid,
  input  logic [SET_W-1:0] evictSet,
  input  logic [WAY_W-1:0] evictWay,
  input  logic [11:0]      csrAddr,
  output logic [31:0]      csrRdData
);

  pfm_pkg::pfm_strobe_t                      strobe;
  logic [LINE_W-1:0]                         useIdx;
  logic [LINE_W-1:0]                         fillIdx;
  logic [LINE_W-1:0]                         evictIdx;
  logic [pfm_pkg::NUM_COUNTS-1:0][CNT_W-1:0] countVal;

  pfm_ctrl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) uCtrl (
    .reqFire     (reqFire),
    .reqTag      (reqTag),
    .reqHit      (reqHit),
    .reqSet      (reqSet),
    .reqWay      (reqWay),
    .mshrMatch   (mshrMatch),
    .mshrMatchPf (mshrMatchPf),
    .mreqPush    (mreqPush),
    .mreqTag     (mreqTag),
    .fillValid   (fillValid),
    .fillIsPf    (fillIsPf),
    .fillSet     (fillSet),
    .fillWay     (fillWay),
    .evictValid  (evictValid),
    .evictSet    (evictSet),
    .evictWay    (evictWay),
    .strobe      (strobe),
    .useIdx      (useIdx),
    .fillIdx     (fillIdx),
    .evictIdx    (evictIdx)
  );

  pfm_datapath #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .useIdx   (useIdx),
    .fillIdx  (fillIdx),
    .evictIdx (evictIdx),
    .countVal (countVal)
  );

  pfm_csr_read #(.CNT_W(CNT_W)) uCsr (
    .clk       (clk),
    .rst       (rst),
    .csrAddr   (csrAddr),
    .countVal  (countVal),
    .csrRdData (csrRdData)
  );

endmodule

// File: rtl/pfm_monitor_chk.sv
module pfm_monitor_chk #(
  parameter int CNT_W = 64,
  parameter int TAG_W = 8
) (
  input logic                                     clk,
  input logic                                     rst,
  input logic                                     reqFire,
  input logic [TAG_W-1:0]                         reqTag,
  input logic                                     mshrMatch,
  input logic                                     mshrMatchPf,
  input logic                                     mreqPush,
  input logic [TAG_W-1:0]                         mreqTag,
  input logic [11:0]                              csrAddr,
  input logic [31:0]                              csrRdData,
  input logic [pfm_pkg::NUM_COUNTS-1:0][CNT_W-1:0] countVal
);

  import pfm_pkg::*;

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  logic [63:0] uniqWide;
  logic        pfPush;
  logic        lateEvt;
  logic        addrKnown;

  assign uniqWide  = 64'(countVal[IDX_UNIQUE]);
  assign pfPush    = mreqPush && mreqTag[0];
  assign lateEvt   = reqFire && reqTag[0] && mshrMatch && !mshrMatchPf;
  assign addrKnown = (csrAddr >= CSR_LO_BASE && csrAddr < CSR_LO_BASE + 12'd3) ||
                     (csrAddr >= CSR_HI_BASE && csrAddr < CSR_HI_BASE + 12'd3);

  assert_unique_step_R1: assert property (@(posedge clk) disable iff (rst)
    (pfPush && countVal[IDX_UNIQUE] != MAX_VAL) |=>
      countVal[IDX_UNIQUE] == $past(countVal[IDX_UNIQUE]) + CNT_W'(1));

  assert_unique_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !pfPush |=> $stable(countVal[IDX_UNIQUE]));

  assert_late_step_R2: assert property (@(posedge clk) disable iff (rst)
    (lateEvt && countVal[IDX_LATE] != MAX_VAL) |=>
      countVal[IDX_LATE] == $past(countVal[IDX_LATE]) + CNT_W'(1));

  assert_late_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !lateEvt |=> $stable(countVal[IDX_LATE]));

  genvar si;
  generate
    for (si = 0; si < NUM_COUNTS; si++) begin : g_sat
      assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (countVal[si] == MAX_VAL) |=> (countVal[si] == MAX_VAL));
    end
  endgenerate

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (countVal == '0 && csrRdData == 32'd0));

  assert_read_low_R9: assert property (@(posedge clk) disable iff (rst)
    (csrAddr == CSR_LO_BASE) |=> csrRdData == $past(uniqWide[31:0]));

  assert_read_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    !addrKnown |=> csrRdData == 32'd0);

endmodule

bind pfm_monitor pfm_monitor_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .reqFire     (reqFire),
  .reqTag      (reqTag),
  .mshrMatch   (mshrMatch),
  .mshrMatchPf (mshrMatchPf),
  .mreqPush    (mreqPush),
  .mreqTag     (mreqTag),
  .csrAddr     (csrAddr),
  .csrRdData   (csrRdData),
  .countVal    (countVal)
);

// File: tb/sim_pfm_monitor.sv
`timescale 1ns/1ps
module sim_pfm_monitor;

  localparam int NSETS = 16;
  localparam int NWAYS = 4;
  localparam int NLINES = NSETS * NWAYS;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqFire, reqHit, mshrMatch, mshrMatchPf, mreqPush;
  logic [7:0]  reqTag, mreqTag;
  logic [3:0]  reqSet, fillSet, evictSet;
  logic [1:0]  reqWay, fillWay, evictWay;
  logic        fillValid, fillIsPf, evictValid;
  logic [11:0] csrAddr;
  logic [31:0] csrRdData, csrRdData1;

  always #2 clk = ~clk;

  pfm_monitor u0 (
    .clk(clk), .rst(rst), .reqFire(reqFire), .reqTag(reqTag), .reqHit(reqHit),
    .reqSet(reqSet), .reqWay(reqWay), .mshrMatch(mshrMatch), .mshrMatchPf(mshrMatchPf),
    .mreqPush(mreqPush), .mreqTag(mreqTag), .fillValid(fillValid), .fillIsPf(fillIsPf),
    .fillSet(fillSet), .fillWay(fillWay), .evictValid(evictValid), .evictSet(evictSet),
    .evictWay(evictWay), .csrAddr(csrAddr), .csrRdData(csrRdData)
  );

  // Narrow-count copy fed the same events, used for the ceiling check.
  pfm_monitor #(.CNT_W(4)) u1 (
    .clk(clk), .rst(rst), .reqFire(reqFire), .reqTag(reqTag), .reqHit(reqHit),
    .reqSet(reqSet), .reqWay(reqWay), .mshrMatch(mshrMatch), .mshrMatchPf(mshrMatchPf),
    .mreqPush(mreqPush), .mreqTag(mreqTag), .fillValid(fillValid), .fillIsPf(fillIsPf),
    .fillSet(fillSet), .fillWay(fillWay), .evictValid(evictValid), .evictSet(evictSet),
    .evictWay(evictWay), .csrAddr(csrAddr), .csrRdData(csrRdData1)
  );

  typedef struct packed {
    logic       rf;  logic rpf; logic rhit; logic [3:0] rset; logic [1:0] rway;
    logic       mp;  logic mpf; logic mm;   logic mmpf;
    logic       fv;  logic fpf; logic [3:0] fset; logic [1:0] fway;
    logic       ev;  logic [3:0] eset; logic [1:0] eway;
    logic [7:0] eU;  logic [7:0] eN; logic [7:0] eL;
  } vecT;

  // Fields: rf rpf rhit rset rway | mp mpf mm mmpf | fv fpf fset fway | ev eset eway | unique unused late
  localparam vecT TABLE [16] = '{
    '{1,1,0,3,1, 1,1,0,0, 0,0,0,0, 0,0,0, 1,0,0}, // R1 prefetch miss pushed
    '{0,0,0,0,0, 0,0,0,0, 1,1,3,1, 0,0,0, 1,0,0}, // R3 prefetch fill
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,3,1, 1,1,0}, // R5 evicted unused
    '{1,0,0,5,2, 1,0,0,0, 0,0,0,0, 0,0,0, 1,1,0}, // R1 demand push ignored
    '{1,1,0,5,2, 0,0,1,0, 1,1,5,2, 0,0,0, 1,1,1}, // R2 late against demand miss
    '{1,0,1,5,2, 0,0,0,0, 0,0,0,0, 0,0,0, 1,1,1}, // R4 demand hit marks used
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,5,2, 1,1,1}, // R5 used line not counted
    '{1,1,0,7,0, 0,0,1,1, 1,1,7,0, 1,7,0, 1,1,1}, // R2 match is prefetch; R6 evict+fill
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,7,0, 1,2,1}, // R6 fill state kept
    '{1,1,0,2,3, 1,1,0,0, 1,1,2,3, 0,0,0, 2,2,1}, // R1 R3
    '{1,1,1,2,3, 0,0,0,0, 0,0,0,0, 0,0,0, 2,2,1}, // R4 prefetch hit not use
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,2,3, 2,3,1}, // R4 R5
    '{1,0,0,0,0, 0,0,1,0, 0,0,0,0, 0,0,0, 2,3,1}, // R2 demand with match
    '{0,0,0,0,0, 0,0,0,0, 1,0,4,1, 0,0,0, 2,3,1}, // R3 demand fill
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,4,1, 2,3,1}, // R3 demand fill not unused
    '{0,0,0,0,0, 0,0,0,0, 0,0,0,0, 1,3,1, 2,3,1}  // R5 re-evict cleared line
  };

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  bit          refPf [NLINES];
  bit          refUsed [NLINES];
  logic [63:0] refU, refN, refL;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    reqFire = 0; reqTag = 0; reqHit = 0; reqSet = 0; reqWay = 0;
    mshrMatch = 0; mshrMatchPf = 0; mreqPush = 0; mreqTag = 0;
    fillValid = 0; fillIsPf = 0; fillSet = 0; fillWay = 0;
    evictValid = 0; evictSet = 0; evictWay = 0;
  endtask

  task automatic apply(input vecT v);
    reqFire = v.rf; reqTag = {7'd0, v.rpf}; reqHit = v.rhit; reqSet = v.rset; reqWay = v.rway;
    mreqPush = v.mp; mreqTag = {7'd0, v.mpf}; mshrMatch = v.mm; mshrMatchPf = v.mmpf;
    fillValid = v.fv; fillIsPf = v.fpf; fillSet = v.fset; fillWay = v.fway;
    evictValid = v.ev; evictSet = v.eset; evictWay = v.eway;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic readCsr(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
    csrAddr = a;
    @(posedge clk); #1;
    d0 = csrRdData;
    d1 = csrRdData1;
    csrAddr = 12'h000;
  endtask

  task automatic doReset();
    rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    for (int i = 0; i < NLINES; i++) begin refPf[i] = 0; refUsed[i] = 0; end
    refU = 0; refN = 0; refL = 0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] a, b;
    readCsr(12'hB20, a, b); check({"R1 unique ", tag}, 64'(a), refU);
    readCsr(12'hB21, a, b); check({"R5 unused ", tag}, 64'(a), refN);
    readCsr(12'hB22, a, b); check({"R2 late ", tag},   64'(a), refL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d0, d1;
    vecT rv;
    idle();
    csrAddr = 12'h000;
    doReset();

    // R8 reset state
    readCsr(12'hB20, d0, d1); check("R8 reset unique", 64'(d0), 0);
    readCsr(12'hB21, d0, d1); check("R8 reset unused", 64'(d0), 0);
    readCsr(12'hB22, d0, d1); check("R8 reset late",   64'(d0), 0);

    // Table walk
    for (int t = 0; t < 16; t++) begin
      apply(TABLE[t]);
      refU = 64'(TABLE[t].eU); refN = 64'(TABLE[t].eN); refL = 64'(TABLE[t].eL);
      checkAll($sformatf("table[%0d]", t));
    end

    // R9 high words and R10 unmapped addresses
    readCsr(12'hBA0, d0, d1); check("R9 high unique", 64'(d0), 0);
    readCsr(12'hBA1, d0, d1); check("R9 high unused", 64'(d0), 0);
    readCsr(12'hBA2, d0, d1); check("R9 high late",   64'(d0), 0);
    readCsr(12'hB23, d0, d1); check("R10 addr B23", 64'(d0), 0);
    readCsr(12'hB1F, d0, d1); check("R10 addr B1F", 64'(d0), 0);
    readCsr(12'h320, d0, d1); check("R10 addr 320", 64'(d0), 0);

    // R8 reset clears line flags: prefetched line evicted after reset is not counted
    rv = '0; rv.fv = 1; rv.fpf = 1; rv.fset = 9; rv.fway = 0; apply(rv);
    doReset();
    rv = '0; rv.ev = 1; rv.eset = 9; rv.eway = 0; apply(rv);
    checkAll("after reset");

    // Random phase with reference model
    for (int c = 0; c < 400; c++) begin
      int ui, fi, ei;
      rv = '0;
      rv.rf   = ($urandom_range(0, 1) == 1);
      rv.rpf  = $urandom_range(0, 1);
      rv.rhit = $urandom_range(0, 1);
      rv.rset = 4'($urandom_range(0, 15)); rv.rway = 2'($urandom_range(0, 3));
      rv.mp   = ($urandom_range(0, 9) < 3); rv.mpf = $urandom_range(0, 1);
      rv.mm   = ($urandom_range(0, 9) < 3); rv.mmpf = $urandom_range(0, 1);
      rv.fv   = ($urandom_range(0, 9) < 3); rv.fpf = $urandom_range(0, 1);
      rv.fset = 4'($urandom_range(0, 15)); rv.fway = 2'($urandom_range(0, 3));
      rv.ev   = ($urandom_range(0, 9) < 3);
      rv.eset = 4'($urandom_range(0, 15)); rv.eway = 2'($urandom_range(0, 3));
      ui = rv.rset * NWAYS + rv.rway;
      fi = rv.fset * NWAYS + rv.fway;
      ei = rv.eset * NWAYS + rv.eway;
      if (rv.mp && rv.mpf) refU++;
      if (rv.rf && rv.rpf && rv.mm && !rv.mmpf) refL++;
      if (rv.ev && refPf[ei] && !refUsed[ei]) refN++;
      if (rv.rf && rv.rhit && !rv.rpf) refUsed[ui] = 1;
      if (rv.ev) begin refPf[ei] = 0; refUsed[ei] = 0; end
      if (rv.fv) begin refPf[fi] = rv.fpf; refUsed[fi] = 0; end
      apply(rv);
      if (c % 100 == 99) checkAll($sformatf("random cycle %0d", c));
    end

    // R7 ceiling on the narrow copy, exact count on the wide one
    doReset();
    for (int k = 0; k < 20; k++) begin
      rv = '0; rv.mp = 1; rv.mpf = 1; apply(rv);
    end
    readCsr(12'hB20, d0, d1);
    check("R7 narrow saturates", 64'(d1), 15);
    check("R1 wide count 20",    64'(d0), 20);
    readCsr(12'hBA0, d0, d1);
    check("R7 narrow high word", 64'(d1), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule